// File: doc/BRIEF.md
# DMA Burst Planner

This block turns one DMA transfer request into the sequence of bus bursts that a 32-bit bus master issues for it. A request gives a byte start address (word aligned), a length in 32-bit words and a requested burst length, together with three mode bits. The mode bits select fixed-size bursts, bursts aligned to their own size, and a mixed policy that uses undefined-length bursts only when they are long. The planner presents one burst at a time (start address, beat count and burst-type code), and holds it until the bus side accepts it. It then steps to the next burst, and goes idle once every word has been covered.

The deepest burst the block may use is bounded by a FIFO size parameter. A request above that bound is clamped and raises a sticky error flag. Data beats, byte lanes and descriptor handling belong to other blocks.

Top module: `dma_burst_planner`

## Requirements
- R1: After reset `burst_valid` and `pbl_err` are 0.
- R2: A `start` pulse while idle with a nonzero `total_words` makes the first burst visible on `burst_valid` in the cycle after the start edge. A `start` while a transfer is running is ignored, and a zero length produces no burst.
- R3: A burst is held unchanged until `burst_ready` is high. Each accepted burst moves the address by beats×4 bytes, and the beats of all bursts add up to `total_words`. `burst_valid` drops in the cycle after the last burst is accepted.
- R4: The effective burst length is the requested `pbl` clamped to a limit set by FIFO_BYTES: 8 for 128 or fewer bytes, 32 up to 256, 64 up to 512, 128 up to 1024, and 255 above that. A request of 0 is treated as 1. A request above the limit sets `pbl_err`, which stays set until reset.
- R5: With `fixed_mode`=0 and `mixed_mode`=0, each burst has min(effective length, remaining) beats and type INCR.
- R6: With `fixed_mode`=0 and `mixed_mode`=1, a burst longer than 16 beats is INCR. A burst of 16 or fewer is cut to the largest of 16, 8, 4 or 1 beats that fits, and is issued as that fixed type.
- R7: With `fixed_mode`=0 and `align_mode`=1, only the first burst is shortened. It stops where the next burst would start on a multiple of (effective length × 4) bytes.
- R8: With `fixed_mode`=1 every burst is 16, 8, 4 or 1 beats. The size is the largest one that does not exceed the programmed fixed size (the largest of these not above the effective length) or the remaining words. `mixed_mode` has no effect in this case.
- R9: With `fixed_mode`=1 and `align_mode`=1, each burst of s beats also starts on a multiple of s×4 bytes. The size is reduced as far as SINGLE to meet this.
- R10: `burst_type` uses the AHB encoding: SINGLE=3'b000, INCR=3'b001, INCR4=3'b011, INCR8=3'b101, INCR16=3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Transfer request pulse |
| start_addr | input | ADDR_W | Byte start address, word aligned |
| total_words | input | LEN_W | Transfer length in words |
| pbl | input | PBL_W | Requested burst length in beats |
| fixed_mode | input | 1 | Use fixed-size bursts only |
| align_mode | input | 1 | Align bursts to their size |
| mixed_mode | input | 1 | INCR for long bursts, fixed types for short ones |
| burst_valid | output | 1 | A burst is presented |
| burst_ready | input | 1 | The bus accepts the presented burst |
| burst_addr | output | ADDR_W | Byte address of the burst |
| burst_beats | output | PBL_W | Beats in the burst |
| burst_type | output | 3 | Burst type code |
| pbl_err | output | 1 | Sticky clamp flag |

## Verification
The burst outputs are driven from registers, so a new burst is due one edge after the start edge or after the edge that accepted the previous burst. `pbl_err` is due one edge after the start edge. The bench drives and samples on falling edges only. At each falling edge it compares the outputs with the head of a queue of expected bursts, which a behavioural model builds when the request is made. The head is removed only in the cycle in which the bench drives `burst_ready` high against a presented burst, so stalls and acceptances line up with the design cycle for cycle.

// File: rtl/dma_burst_planner.sv
module dma_burst_planner #(
  parameter int FIFO_BYTES = 256,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int PBL_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  total_words,
  input  logic [PBL_W-1:0]  pbl,
  input  logic              fixed_mode,
  input  logic              align_mode,
  input  logic              mixed_mode,
  output logic              burst_valid,
  input  logic              burst_ready,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [PBL_W-1:0]  burst_beats,
  output logic [2:0]        burst_type,
  output logic              pbl_err
);
  localparam int LIMIT = (FIFO_BYTES <= 128)  ? 8   :
                         (FIFO_BYTES <= 256)  ? 32  :
                         (FIFO_BYTES <= 512)  ? 64  :
                         (FIFO_BYTES <= 1024) ? 128 : (2**PBL_W) - 1;
  localparam logic [PBL_W-1:0] LIM = PBL_W'(LIMIT);
  localparam logic [PBL_W-1:0] B16 = PBL_W'(16);
  localparam logic [PBL_W-1:0] B8  = PBL_W'(8);
  localparam logic [PBL_W-1:0] B4  = PBL_W'(4);

  logic              active, first_q, fb_q, aal_q, mb_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [PBL_W-1:0]  epbl_q, cap, gap, base, pgm, fb_src, src, beats;
  logic [2:0]        btype;

  wire [ADDR_W-3:0] wa        = addr_q[ADDR_W-1:2];
  wire [PBL_W-1:0]  req       = (pbl == '0) ? PBL_W'(1) : pbl;
  wire              accept    = active && burst_ready;

  assign cap    = (rem_q < LEN_W'(epbl_q)) ? PBL_W'(rem_q) : epbl_q;
  assign gap    = epbl_q - PBL_W'(wa % (ADDR_W-2)'(epbl_q));
  assign base   = (aal_q && first_q && gap < cap) ? gap : cap;
  assign pgm    = (epbl_q >= B16) ? B16 : (epbl_q >= B8) ? B8 : (epbl_q >= B4) ? B4 : PBL_W'(1);
  assign fb_src = (pgm < cap) ? pgm : cap;

  wire fixed_sel = fb_q || (mb_q && base <= B16);
  wire chk       = fb_q && aal_q;
  assign src     = fb_q ? fb_src : base;

  always_comb begin
    if (!fixed_sel)                                   beats = base;
    else if (src >= B16 && (!chk || wa[3:0] == 4'd0)) beats = B16;
    else if (src >= B8  && (!chk || wa[2:0] == 3'd0)) beats = B8;
    else if (src >= B4  && (!chk || wa[1:0] == 2'd0)) beats = B4;
    else                                              beats = PBL_W'(1);
  end

  always_comb begin
    if (!fixed_sel)          btype = 3'b001;
    else if (beats == B16)   btype = 3'b111;
    else if (beats == B8)    btype = 3'b101;
    else if (beats == B4)    btype = 3'b011;
    else                     btype = 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      first_q <= 1'b0;
      fb_q    <= 1'b0;
      aal_q   <= 1'b0;
      mb_q    <= 1'b0;
      addr_q  <= '0;
      rem_q   <= '0;
      epbl_q  <= PBL_W'(1);
      pbl_err <= 1'b0;
    end else if (!active) begin
      if (start) begin
        active  <= (total_words != '0);
        first_q <= 1'b1;
        fb_q    <= fixed_mode;
        aal_q   <= align_mode;
        mb_q    <= mixed_mode;
        addr_q  <= start_addr;
        rem_q   <= total_words;
        epbl_q  <= (req > LIM) ? LIM : req;
        if (req > LIM) pbl_err <= 1'b1;
      end
    end else if (accept) begin
      first_q <= 1'b0;
      addr_q  <= addr_q + (ADDR_W'(beats) << 2);
      rem_q   <= rem_q - LEN_W'(beats);
      if (rem_q == LEN_W'(beats)) active <= 1'b0;
    end
  end

  assign burst_valid = active;
  assign burst_addr  = addr_q;
  assign burst_beats = beats;
  assign burst_type  = btype;

  p_beats_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> (burst_beats != '0 && burst_beats <= LIM));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid && !burst_ready) |=>
      (burst_valid && $stable(burst_addr) && $stable(burst_beats) && $stable(burst_type)));
  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid && burst_ready && rem_q > LEN_W'(burst_beats)) |=>
      (burst_valid && burst_addr == $past(burst_addr) + (ADDR_W'($past(burst_beats)) << 2)));
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pbl_err |=> pbl_err);
  p_mixed_long_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid && !fb_q && mb_q && burst_beats > B16) |-> burst_type == 3'b001);
  p_fixed_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid && fb_q && aal_q) |-> ((burst_addr[5:2] & 4'(burst_beats - PBL_W'(1))) == 4'd0));
  p_fixed_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid && fb_q) |-> (burst_beats == B16 || burst_beats == B8 ||
                               burst_beats == B4 || burst_beats == PBL_W'(1)));
endmodule

// File: tb/dma_burst_planner_tb_top.sv
module dma_burst_planner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [15:0] total_words = '0;
  logic [7:0]  pbl = '0;
  logic        fixed_mode = 1'b0, align_mode = 1'b0, mixed_mode = 1'b0;
  logic        burst_ready = 1'b0;
  logic        burst_valid, pbl_err;
  logic [31:0] burst_addr;
  logic [7:0]  burst_beats;
  logic [2:0]  burst_type;

  int checks = 0, errors = 0, cyc = 0;
  bit exp_err = 0, finished = 0;
  int qa[$], qb[$], qt[$];

  always #5 clk = ~clk;

  dma_burst_planner dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .total_words(total_words), .pbl(pbl), .fixed_mode(fixed_mode),
    .align_mode(align_mode), .mixed_mode(mixed_mode), .burst_valid(burst_valid),
    .burst_ready(burst_ready), .burst_addr(burst_addr), .burst_beats(burst_beats),
    .burst_type(burst_type), .pbl_err(pbl_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int code_of(input int s, input bit fixed);
    if (!fixed) return 1;
    case (s)
      16: return 7;
      8:  return 5;
      4:  return 3;
      default: return 0;
    endcase
  endfunction

  function automatic void plan(input int addr, input int total, input int p,
                               input bit fb, input bit aal, input bit mb);
    int sizes[4] = '{16, 8, 4, 1};
    int e, w, rem, b, s, pg;
    bit first = 1;
    e = (p == 0) ? 1 : ((p > 32) ? 32 : p);
    w = addr / 4;
    rem = total;
    while (rem > 0) begin
      if (fb) begin
        pg = 1;
        foreach (sizes[k]) if (pg == 1 && sizes[k] <= e) pg = sizes[k];
        b = (pg < rem) ? pg : rem;
        s = 1;
        foreach (sizes[k])
          if (s == 1 && sizes[k] <= b && (!aal || (w % sizes[k]) == 0)) s = sizes[k];
        qa.push_back(w * 4); qb.push_back(s); qt.push_back(code_of(s, 1));
      end else begin
        b = (e < rem) ? e : rem;
        if (aal && first && (e - (w % e)) < b) b = e - (w % e);
        if (mb && b <= 16) begin
          s = 1;
          foreach (sizes[k]) if (s == 1 && sizes[k] <= b) s = sizes[k];
          qa.push_back(w * 4); qb.push_back(s); qt.push_back(code_of(s, 1));
        end else begin
          s = b;
          qa.push_back(w * 4); qb.push_back(s); qt.push_back(1);
        end
      end
      w += s; rem -= s; first = 0;
    end
  endfunction

  // poke: drive a conflicting start in the middle of the run (R2 ignore case)
  task automatic run(input string tag, input int addr, input int total, input int p,
                     input bit fb, input bit aal, input bit mb, input bit poke);
    int guard = 0;
    @(negedge clk);
    check({tag, " R2 idle before start"}, burst_valid, 0);
    start_addr = addr; total_words = 16'(total); pbl = 8'(p);
    fixed_mode = fb; align_mode = aal; mixed_mode = mb; start = 1'b1;
    plan(addr, total, p, fb, aal, mb);
    @(negedge clk);
    start = 1'b0;
    if (p > 32) exp_err = 1;
    forever begin
      cyc++;
      check({tag, " R4 pbl_err"}, pbl_err, int'(exp_err));
      if (qa.size() == 0) begin
        check({tag, " R3 valid low when done"}, burst_valid, 0);
        break;
      end
      check({tag, " R2/R3 valid"}, burst_valid, 1);
      check({tag, " R3 addr"}, burst_addr, qa[0]);
      check({tag, " R5-R9 beats"}, burst_beats, qb[0]);
      check({tag, " R10 type"}, burst_type, qt[0]);
      if (poke && guard == 1) begin
        start = 1'b1; start_addr = 32'h9000; total_words = 16'd3; pbl = 8'd1;
      end else start = 1'b0;
      burst_ready = ((cyc % 3) != 1);
      if (burst_ready) begin
        void'(qa.pop_front()); void'(qb.pop_front()); void'(qt.pop_front());
      end
      guard++;
      if (guard > 500) begin
        check({tag, " watchdog"}, 1, 0);
        break;
      end
      @(negedge clk);
    end
    burst_ready = 1'b0; start = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 valid after reset", burst_valid, 0);
    check("R1 pbl_err after reset", pbl_err, 0);
    rst_n = 1'b1;
    run("R5 plain",        32'h1000, 40, 16, 0, 0, 0, 0);
    run("R5 pbl0",         32'h2000, 3,  0,  0, 0, 0, 0);
    run("R7 first cut",    32'h1004, 37, 20, 0, 1, 0, 0);
    run("R6 mixed",        32'h1004, 37, 20, 0, 1, 1, 0);
    run("R6 mixed short",  32'h3000, 23, 12, 0, 0, 1, 0);
    run("R2 zero length",  32'h4000, 0,  8,  0, 0, 0, 0);
    run("R8 fixed",        32'h5004, 21, 8,  1, 0, 1, 0);
    run("R9 fixed align",  32'h2008, 50, 16, 1, 1, 0, 0);
    run("R2 busy start",   32'h6000, 60, 4,  0, 0, 0, 1);
    run("R4 clamp",        32'h7000, 70, 40, 0, 0, 1, 0);
    run("R4 sticky",       32'h7100, 9,  4,  1, 1, 0, 0);
    run("R9 odd addr",     32'h710c, 30, 32, 1, 1, 1, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule